// File: doc/BRIEF.md
# Two-Bank Split Output Stage with Coding Formats and Test Patterns

This block is the output stage that follows a six-bit converter core. Each clock it may accept one seven-bit sample: a six-bit code with an overrange flag above it. The block deals the accepted samples alternately into two output banks, so each bank changes at most once every two clocks and the two banks change on different edges. The first sample accepted after reset always goes to bank A. Each bank has its own data-ready line, which toggles on every edge that loads that bank. Downstream logic can capture each bank on either edge of its own ready line, at half the sample rate.

Two control inputs pick the output coding. One flips the top code bit and the other flips the five lower code bits, which gives straight binary, inverted binary, two's complement and inverted two's complement. The overrange bit is never flipped. A test input replaces the words loaded into the banks with two fixed alternating checkerboard patterns. The sample pipeline keeps running behind the replacement, so real data returns on the first load after the test input falls.

Top module: `bank_split_out`

## Requirements
- R1: While rstN is low, both bank words are zero and both ready lines are low.
- R2: The first valid sample after reset is loaded into bank A. A sample presented with sampleValid high before clock edge k is visible on its bank after edge k+1.
- R3: Valid samples go to the banks in strict turn: A, B, A, B and so on. No bank is loaded on two consecutive edges.
- R4: A bank word changes only on an edge where that bank's ready line toggles. Each load toggles only that bank's ready line.
- R5: With msbInv high, code bit 5 of each loaded word is the inverse of the sample's bit 5.
- R6: With lowInv high, code bits 4 down to 0 of each loaded word are inverted.
- R7: Bit 6, the overrange flag, passes through unchanged in every coding format.
- R8: A cycle with sampleValid low loads no bank and toggles no ready line. The next bank in turn stays the same.
- R9: With testMode high at a loading edge, the first such load loads pattern one, 1010101 on bits 6..0 (even bit positions high).
- R10: While testMode stays high, successive loads alternate between pattern one and pattern two, 0101010 on bits 6..0, across both banks in load order.
- R11: On the first loading edge with testMode low again, the bank receives the formatted sample captured one edge earlier. The sample pipeline keeps running during test mode.
- R12: In test mode the ready lines keep toggling on each bank load, and the banks keep alternating, exactly as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 7 | Sample: bit 6 overrange, bits 5..0 code |
| sampleValid | input | 1 | sampleIn holds a sample this cycle |
| msbInv | input | 1 | Invert code bit 5 |
| lowInv | input | 1 | Invert code bits 4..0 |
| testMode | input | 1 | Replace loaded words with checkerboard patterns |
| bankA | output | 7 | Bank A word |
| bankB | output | 7 | Bank B word |
| drA | output | 1 | Bank A ready, toggles per bank A load |
| drB | output | 1 | Bank B ready, toggles per bank B load |

## Verification
The bench runs every one of the 128 sample values through all four coding settings back to back. This separates a wrong bit-5 flip from a wrong low-field flip, and any leak into the overrange flag. A pseudo-random valid pattern with gaps shows whether the bank turn and the ready lines follow accepted samples rather than clock edges. Test-mode runs, some with gaps and with entry on either bank, separate the pattern order from the bank order. The first load after exit shows whether the pipeline kept converting underneath the patterns.

// File: rtl/bso_pkg.sv
package bso_pkg;
  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic loadA;   // write bank A this edge
    logic loadB;   // write bank B this edge
    logic usePat;  // load a checkerboard instead of the sample
    logic patSel;  // 0: even bits high, 1: odd bits high
  } bsoStrobes_t;
endpackage

// File: rtl/bso_ctrl.sv
module bso_ctrl
  import bso_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        testMode,
  output bsoStrobes_t strobes
);
  logic pipeValid;  // a formatted sample waits in the datapath stage
  logic bankSel;    // 0: next load goes to bank A
  logic patToggle;  // 1: next test load uses the second pattern

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeValid <= 1'b0;
      bankSel   <= 1'b0;
      patToggle <= 1'b0;
    end else begin
      pipeValid <= sampleValid;
      if (pipeValid) bankSel <= ~bankSel;
      if (!testMode)      patToggle <= 1'b0;
      else if (pipeValid) patToggle <= ~patToggle;
    end
  end

  always_comb begin
    strobes.loadA  = pipeValid & ~bankSel;
    strobes.loadB  = pipeValid &  bankSel;
    strobes.usePat = testMode;
    strobes.patSel = patToggle;
  end
endmodule

// File: rtl/bso_path.sv
module bso_path
  import bso_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W:0]   sampleIn,
  input  logic              msbInv,
  input  logic              lowInv,
  input  bsoStrobes_t       strobes,
  output logic [CODE_W:0]   bankA,
  output logic [CODE_W:0]   bankB,
  output logic              drA,
  output logic              drB
);
  localparam int WORD_W = CODE_W + 1;

  logic [WORD_W-1:0] fmtMask;
  logic [WORD_W-1:0] pipeWord;
  logic [WORD_W-1:0] patOne;
  logic [WORD_W-1:0] loadWord;

  // overrange bit never inverted; top code bit and low field independently
  assign fmtMask = {1'b0, msbInv, {(CODE_W-1){lowInv}}};

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_pat
      assign patOne[i] = (i % 2 == 0);
    end
  endgenerate

  always_comb begin
    if (strobes.usePat) loadWord = strobes.patSel ? ~patOne : patOne;
    else                loadWord = pipeWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeWord <= '0;
      bankA    <= '0;
      bankB    <= '0;
      drA      <= 1'b0;
      drB      <= 1'b0;
    end else begin
      pipeWord <= sampleIn ^ fmtMask;
      if (strobes.loadA) begin
        bankA <= loadWord;
        drA   <= ~drA;
      end
      if (strobes.loadB) begin
        bankB <= loadWord;
        drB   <= ~drB;
      end
    end
  end
endmodule

// File: rtl/bank_split_out.sv
module bank_split_out
  import bso_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CODE_W:0] sampleIn,
  input  logic            sampleValid,
  input  logic            msbInv,
  input  logic            lowInv,
  input  logic            testMode,
  output logic [CODE_W:0] bankA,
  output logic [CODE_W:0] bankB,
  output logic            drA,
  output logic            drB
);
  bsoStrobes_t strobes;

  bso_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .testMode(testMode), .strobes(strobes)
  );

  bso_path #(.CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .msbInv(msbInv),
    .lowInv(lowInv), .strobes(strobes), .bankA(bankA), .bankB(bankB),
    .drA(drA), .drB(drB)
  );
endmodule

// File: rtl/bso_chk.sv
module bso_chk #(
  parameter int CODE_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic [CODE_W:0] sampleIn,
  input logic            sampleValid,
  input logic            msbInv,
  input logic            lowInv,
  input logic            testMode,
  input logic [CODE_W:0] bankA,
  input logic [CODE_W:0] bankB,
  input logic            drA,
  input logic            drB
);
  localparam int WORD_W = CODE_W + 1;
  logic [WORD_W-1:0] patOne;
  always_comb
    for (int i = 0; i < WORD_W; i++) patOne[i] = (i % 2 == 0);

  // R1
  always_comb if (!rstN) reset_state_chk: assert (!drA && !drB);

  // R4
  bank_a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bankA) |-> !$stable(drA));
  // R4
  bank_b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bankB) |-> !$stable(drB));
  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(drA) && !$stable(drB)));
  // R3
  no_double_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(drA) |=> $stable(drA));
  // R8
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleValid, 2) |-> ($stable(drA) && $stable(drB)));
  // R10
  test_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(drA) && $past(testMode)) |-> (bankA == patOne || bankA == ~patOne));
endmodule

bind bank_split_out bso_chk #(.CODE_W(CODE_W)) uChk (.*);

// File: tb/sim_bank_split_out.sv
`timescale 1ns/1ps
module sim_bank_split_out;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, sampleValid, msbInv, lowInv, testMode;
  logic [6:0] sampleIn, bankA, bankB;
  logic       drA, drB;

  int errs = 0, checks = 0;

  // requirement-level model state
  logic       mPV, mSel, mPT, mDrA, mDrB;
  logic [6:0] mPW, mA, mB;

  localparam logic [6:0] PAT1 = 7'h55;
  localparam logic [6:0] PAT2 = 7'h2A;

  bank_split_out u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .msbInv(msbInv), .lowInv(lowInv), .testMode(testMode),
    .bankA(bankA), .bankB(bankB), .drA(drA), .drB(drB)
  );

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, logic [6:0] s, logic v, logic m, logic l, logic t);
    logic [6:0] w;
    sampleIn = s; sampleValid = v; msbInv = m; lowInv = l; testMode = t;
    @(posedge clk);
    if (mPV) begin
      if (t) begin w = mPT ? PAT2 : PAT1; mPT = ~mPT; end
      else begin w = mPW; mPT = 1'b0; end
      if (!mSel) begin mA = w; mDrA = ~mDrA; end
      else       begin mB = w; mDrB = ~mDrB; end
      mSel = ~mSel;
    end else if (!t) mPT = 1'b0;
    mPV = v;
    mPW = s ^ (m ? 7'h20 : 7'h00) ^ (l ? 7'h1F : 7'h00);
    @(negedge clk);
    chk(tag, bankA, mA);
    chk(tag, bankB, mB);
    chk(tag, {5'd0, drA, drB}, {5'd0, mDrA, mDrB});
  endtask

  initial begin
    #(5.0 * 200000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rstN = 1'b0; sampleIn = '0; sampleValid = 1'b0;
    msbInv = 1'b0; lowInv = 1'b0; testMode = 1'b0;
    mPV = 0; mSel = 0; mPT = 0; mDrA = 0; mDrB = 0; mPW = 0; mA = 0; mB = 0;
    repeat (3) @(negedge clk);
    chk("R1", bankA, 7'h00);
    chk("R1", bankB, 7'h00);
    chk("R1", {5'd0, drA, drB}, 7'h00);
    rstN = 1'b1;

    // R2: first sample to bank A after two edges
    cyc("R2", 7'h2A, 1, 0, 0, 0);
    chk("R2 not yet", {5'd0, drA, drB}, 7'h00);
    cyc("R2", 7'h00, 0, 0, 0, 0);
    chk("R2 bank A", bankA, 7'h2A);
    chk("R2 ready", {5'd0, drA, drB}, 7'b0000010);
    cyc("R2", 7'h00, 0, 0, 0, 0);

    // R3 R5 R6 R7: every sample under every coding setting
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 128; s++)
        cyc("R3 R5 R6 R7", 7'(s), 1, f[1], f[0], 0);
    cyc("R5", 7'h00, 0, 0, 0, 0);
    cyc("R5", 7'h00, 0, 0, 0, 0);
    chk("R7 overrange", bankB[6], 1'b1);

    // R4 R8: gapped valid stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R4 R8", lfsr[6:0], lfsr[9], lfsr[11], lfsr[12], 0);
    end

    // R9 R10 R12: test entry and hold, continuous valid
    for (int k = 0; k < 2; k++) begin
      cyc("R11", 7'h11, 1, 1, 0, 0);
      if (k == 1) cyc("R11", 7'h33, 1, 0, 1, 0);
      cyc("R9", 7'h40, 1, 0, 0, 1);
      for (int i = 0; i < 7; i++) cyc("R10 R12", 7'(i * 9), 1, 0, 0, 1);
      cyc("R11", 7'h5C, 1, 1, 1, 0);
      cyc("R11", 7'h07, 1, 0, 0, 0);
      cyc("R11", 7'h00, 0, 0, 0, 0);
      cyc("R11", 7'h00, 0, 0, 0, 0);
    end

    // R10 R12: test mode with gaps
    lfsr = 16'h1D2B;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R10 R12", lfsr[6:0], lfsr[3], 0, 0, (i % 16) < 11);
    end
    cyc("R11", 7'h00, 0, 0, 0, 0);
    cyc("R11", 7'h00, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule